// File: doc/BRIEF.md
# Nonvolatile Write Gatekeeper with Self-Timed Cycle

This block sits between the serial command front end of a small serial memory and its storage array. It decides whether a write that the front end has captured may proceed, and then runs a write cycle that lasts a fixed number of system clocks. The decision draws on four things: an active-low write-protect pin, a software write-enable latch, a two-bit block-lock setting and the page address of the request. When the cycle ends, the block either sends one commit strobe with byte lanes to the array or loads a new block-lock setting.

The front end sends one request per serial sequence. The request carries the start address, the count of data bytes shifted in and a four-entry ring of the most recent data bytes. The block maps that ring onto the four lanes of the aligned page and wraps inside the page. A request is only armed while chip select is low. The cycle starts when chip select returns high, so the protect pin can still cancel the request before that point but cannot touch it afterwards.

Top module: `nvw_guard_ctrl`

## Requirements
- R1: After reset `busy`, `commit` and `wel` are 0 and `bp` equals the parameter `BP_RESET` (default 0).
- R2: A `cmd_wrdi` pulse clears `wel`, and otherwise a `cmd_wren` pulse sets it. Both take effect one clock later and are ignored while `busy` is 1.
- R3: A request (`req_arm` high) made while `wel` is 0 starts no cycle and produces no commit.
- R4: A request made while `wp_n` is 0 is refused and `wel` stays 1.
- R5: If `wp_n` goes to 0 after a request is armed and while `cs_n` is still 0, the request is dropped: no busy period and no commit. `wel` stays 1.
- R6: An armed request starts its cycle on the clock where `cs_n` is seen high. `busy` is then 1 for exactly `T_WRITE` clocks, and changes on `wp_n` during that time have no effect.
- R7: On the clock after `busy` falls, a memory write gives a `commit` pulse of exactly one clock with `commit_addr` equal to the page base (start address with its two low bits cleared). On that same clock `wel` reads 0.
- R8: Ring entry k is `req_ring[8k+7:8k]` and holds the latest data byte whose arrival index i (counted from 0) has i mod 4 = k. Byte i goes to lane (start offset + i) mod 4, where lane s is `commit_data[8s+7:8s]` and is enabled by `commit_be[s]`. When `req_len` is 4 or more, all four lanes are enabled. Otherwise only the lanes reached by the first `req_len` bytes are enabled.
- R9: `bp` = 0 locks nothing. `bp` = 1 locks the top quarter of the address space, 2 locks the top half and 3 locks all of it. A memory request whose address is locked is dropped with no busy period and no commit, and `wel` stays 1.
- R10: A request with `req_is_sr` = 1 is not subject to the lock but does need `wel` and `wp_n`. After its cycle, `bp` takes `req_sr_bp`, no commit is issued and `wel` is 0.
- R11: Requests and enable commands that arrive while a cycle is running are ignored, and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low while a serial sequence is in progress |
| wp_n | input | 1 | Write-protect pin, low refuses writes |
| cmd_wren | input | 1 | Pulse: set write-enable latch |
| cmd_wrdi | input | 1 | Pulse: clear write-enable latch |
| req_arm | input | 1 | Pulse: write request captured by the front end |
| req_is_sr | input | 1 | Request targets the block-lock setting instead of the array |
| req_addr | input | ADDR_W | Start byte address of a memory request |
| req_len | input | LEN_W | Number of data bytes shifted in |
| req_ring | input | 32 | Four-entry ring of the latest data bytes |
| req_sr_bp | input | 2 | New block-lock setting for a status request |
| busy | output | 1 | Write cycle running |
| wel | output | 1 | Write-enable latch |
| bp | output | 2 | Current block-lock setting |
| commit | output | 1 | One-clock strobe to the array |
| commit_addr | output | ADDR_W | Page base address of the commit |
| commit_be | output | 4 | Lane enables of the commit |
| commit_data | output | 32 | Lane data of the commit |

## Verification
If the lock decode is wrong, a page that should be refused shows a busy period, or a legal page shows none. The port shows this on the clock after chip select rises. If the cycle counter is wrong, `busy` is held for more or fewer than `T_WRITE` clocks, and the bench counts that span exactly. A fault in lane mapping or the write-enable bookkeeping shows up at the single commit clock, either in `commit_be` and `commit_data` or in `wel`. The bench sweeps every page under every lock setting, with varied offsets and byte counts, so any of these faults surfaces within one request.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    localparam int PAGE_BYTES = 4;
    localparam int LANE_W     = 8;
    localparam int PAGE_W     = PAGE_BYTES * LANE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_BUSY = 2'd2
    } nvw_state_e;
endpackage

// File: rtl/nvw_range_guard.sv
module nvw_range_guard #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        lock_sel,
    output logic              locked
);
    always_comb begin
        case (lock_sel)
            2'd1:    locked = (addr[ADDR_W-1 -: 2] == 2'b11);
            2'd2:    locked = addr[ADDR_W-1];
            2'd3:    locked = 1'b1;
            default: locked = 1'b0;
        endcase
    end
endmodule

// File: rtl/nvw_lane_map.sv
module nvw_lane_map
    import nvw_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic [1:0]          offset,
    input  logic [LEN_W-1:0]    len,
    input  logic [PAGE_W-1:0]   ring,
    output logic [PAGE_BYTES-1:0] lane_en,
    output logic [PAGE_W-1:0]   lane_data
);
    logic full_page;
    assign full_page = (len >= LEN_W'(PAGE_BYTES));

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_lane
        localparam logic [1:0] SL = 2'(s);
        logic [1:0] rank;
        assign rank = SL - offset;
        assign lane_en[s] = full_page || (LEN_W'(rank) < len);
        assign lane_data[s*LANE_W +: LANE_W] = ring[{rank, 3'b000} +: LANE_W];
    end
endmodule

// File: rtl/nvw_write_timer.sv
module nvw_write_timer #(
    parameter int T_WRITE = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (T_WRITE > 1) ? $clog2(T_WRITE) : 1;
    localparam logic [CW-1:0] LAST = CW'(T_WRITE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);                                  // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));                         // R6
endmodule

// File: rtl/nvw_guard_ctrl.sv
module nvw_guard_ctrl
    import nvw_pkg::*;
#(
    parameter int         ADDR_W   = 9,
    parameter int         LEN_W    = 8,
    parameter int         T_WRITE  = 250000,
    parameter logic [1:0] BP_RESET = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              req_arm,
    input  logic              req_is_sr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [31:0]       req_ring,
    input  logic [1:0]        req_sr_bp,
    output logic              busy,
    output logic              wel,
    output logic [1:0]        bp,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [3:0]        commit_be,
    output logic [31:0]       commit_data
);
    typedef struct packed {
        nvw_state_e          st;
        logic                wel;
        logic [1:0]          bp;
        logic                is_sr;
        logic [1:0]          sr_bp;
        logic [ADDR_W-1:0]   addr;
        logic [PAGE_BYTES-1:0] be;
        logic [PAGE_W-1:0]   data;
        logic                commit;
    } ctrl_t;

    ctrl_t q, d;

    logic                  req_locked;
    logic                  cyc_done;
    logic [PAGE_BYTES-1:0] map_en;
    logic [PAGE_W-1:0]     map_data;

    nvw_range_guard #(.ADDR_W(ADDR_W)) u_guard_req (
        .addr     (req_addr),
        .lock_sel (q.bp),
        .locked   (req_locked)
    );

    nvw_lane_map #(.LEN_W(LEN_W)) u_map (
        .offset    (req_addr[1:0]),
        .len       (req_len),
        .ring      (req_ring),
        .lane_en   (map_en),
        .lane_data (map_data)
    );

    nvw_write_timer #(.T_WRITE(T_WRITE)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st == ST_BUSY),
        .done  (cyc_done)
    );

    always_comb begin
        d        = q;
        d.commit = 1'b0;

        if (q.st != ST_BUSY) begin
            if (cmd_wrdi)      d.wel = 1'b0;
            else if (cmd_wren) d.wel = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (req_arm && !cs_n && q.wel && wp_n && (req_is_sr || !req_locked)) begin
                    d.st    = ST_PEND;
                    d.is_sr = req_is_sr;
                    d.sr_bp = req_sr_bp;
                    d.addr  = {req_addr[ADDR_W-1:2], 2'b00};
                    d.be    = map_en;
                    d.data  = map_data;
                end
            end
            ST_PEND: begin
                if (cs_n)       d.st = ST_BUSY;
                else if (!wp_n) d.st = ST_IDLE;
            end
            ST_BUSY: begin
                if (cyc_done) begin
                    d.st  = ST_IDLE;
                    d.wel = 1'b0;
                    if (q.is_sr) d.bp     = q.sr_bp;
                    else         d.commit = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.bp     <= BP_RESET;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st == ST_BUSY);
    assign wel         = q.wel;
    assign bp          = q.bp;
    assign commit      = q.commit;
    assign commit_addr = q.addr;
    assign commit_be   = q.be;
    assign commit_data = q.data;

    logic commit_locked;
    nvw_range_guard #(.ADDR_W(ADDR_W)) u_guard_chk (
        .addr     (commit_addr),
        .lock_sel (bp),
        .locked   (commit_locked)
    );

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);                             // R7
    AST_COMMIT_WEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !wel);                                // R7
    AST_COMMIT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(busy));                         // R6
    AST_NO_WEL_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(wel));                           // R2
    AST_COMMIT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !commit_locked);                      // R9
    AST_BP_ON_SR_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> (!commit && !busy && $past(busy))); // R10
endmodule

// File: tb/nvw_guard_ctrl_bench.sv
module nvw_guard_ctrl_bench;
    localparam int ADDR_W = 9;
    localparam int LEN_W  = 8;
    localparam int T_W    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wp_n = 1'b1, cmd_wren = 1'b0, cmd_wrdi = 1'b0;
    logic req_arm = 1'b0, req_is_sr = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [31:0]       req_ring = '0;
    logic [1:0]        req_sr_bp = '0;
    logic busy, wel, commit;
    logic [1:0] bp;
    logic [ADDR_W-1:0] commit_addr;
    logic [3:0] commit_be;
    logic [31:0] commit_data;

    int total = 0, bad = 0;
    int busy_len;
    logic o_commit, o_wel;
    logic [ADDR_W-1:0] o_addr;
    logic [3:0] o_be;
    logic [31:0] o_data;
    bit extra_seen;

    always #10 clk = ~clk;

    nvw_guard_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .T_WRITE(T_W)) u_nvw_guard_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .req_arm(req_arm),
        .req_is_sr(req_is_sr), .req_addr(req_addr), .req_len(req_len),
        .req_ring(req_ring), .req_sr_bp(req_sr_bp), .busy(busy), .wel(wel),
        .bp(bp), .commit(commit), .commit_addr(commit_addr),
        .commit_be(commit_be), .commit_data(commit_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_wren();
        cmd_wren = 1'b1; @(negedge clk); cmd_wren = 1'b0;
    endtask

    task automatic pulse_wrdi();
        cmd_wrdi = 1'b1; @(negedge clk); cmd_wrdi = 1'b0;
    endtask

    // Arm, raise CS, measure busy span and capture the clock after it.
    task automatic run_req(input bit sr, input int addr, input int len, input logic [31:0] ring,
                           input logic [1:0] nbp, input bit glitch_wp, input bit intrude);
        cs_n = 1'b0; req_arm = 1'b1; req_is_sr = sr;
        req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_ring = ring; req_sr_bp = nbp;
        @(negedge clk);
        req_arm = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        busy_len = 0;
        while (busy && busy_len < 100) begin
            busy_len++;
            if (glitch_wp) wp_n = (busy_len == 2 || busy_len == 3) ? 1'b0 : 1'b1;
            if (intrude && busy_len == 1) begin
                cs_n = 1'b0; req_arm = 1'b1; req_is_sr = 1'b0;
                req_addr = ADDR_W'(addr ^ 32'h20); cmd_wren = 1'b1;
            end else begin
                req_arm = 1'b0; cs_n = 1'b1; cmd_wren = 1'b0;
            end
            @(negedge clk);
        end
        wp_n = 1'b1; req_arm = 1'b0; cs_n = 1'b1; cmd_wren = 1'b0;
        o_commit = commit; o_wel = wel; o_addr = commit_addr; o_be = commit_be; o_data = commit_data;
    endtask

    function automatic bit exp_locked(input int b, input int a);
        return (b == 3) || (b == 2 && a >= 256) || (b == 1 && a >= 384);
    endfunction

    initial begin
        #(20 * 200000);
        $display("FAIL watchdog actual=0 expected=1");
        bad++; total++;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && commit == 0, "R1 busy/commit", {busy, commit}, 0);
        check(wel == 0, "R1 wel", wel, 0);
        check(bp == 2'b00, "R1 bp", bp, 0);

        // R3 no enable latch
        run_req(0, 12, 4, 32'h44332211, 0, 0, 0);
        check(busy_len == 0 && !o_commit, "R3 no wel", busy_len, 0);

        // R2 set then clear
        pulse_wren();
        check(wel == 1, "R2 wren", wel, 1);
        pulse_wrdi();
        check(wel == 0, "R2 wrdi", wel, 0);

        // R4 pin low at request
        pulse_wren();
        wp_n = 1'b0;
        run_req(0, 8, 4, 32'h01020304, 0, 0, 0);
        check(busy_len == 0 && !o_commit, "R4 refused", busy_len, 0);
        check(o_wel == 1, "R4 wel kept", o_wel, 1);

        // R5 abort while cs low
        cs_n = 1'b0; req_arm = 1'b1; req_is_sr = 1'b0; req_addr = 9'd16; req_len = 8'd4;
        @(negedge clk);
        req_arm = 1'b0; wp_n = 1'b0;
        @(negedge clk);
        wp_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        check(busy == 0, "R5 no cycle", busy, 0);
        repeat (T_W + 2) begin
            @(negedge clk);
            if (commit || busy) extra_seen = 1;
        end
        check(!extra_seen, "R5 no commit", extra_seen, 0);
        check(wel == 1, "R5 wel kept", wel, 1);

        // R6/R7/R11: pin glitch during cycle, intruding request and enable
        run_req(0, 37, 3, 32'hDDCCBBAA, 0, 1, 1);
        check(busy_len == T_W, "R6 busy span", busy_len, T_W);
        check(o_commit == 1, "R6 commit despite pin", o_commit, 1);
        check(o_addr == 9'd36, "R7 page base", o_addr, 36);
        check(o_wel == 0, "R7 wel cleared", o_wel, 0);
        @(negedge clk);
        check(commit == 0, "R7 one-clock pulse", commit, 0);
        extra_seen = 0;
        repeat (T_W + 4) begin
            if (commit || busy || wel) extra_seen = 1;
            @(negedge clk);
        end
        check(!extra_seen, "R11 intruder ignored", extra_seen, 0);

        // R10 + R9 + R8 sweep
        for (int b = 0; b < 4; b++) begin
            pulse_wren();
            run_req(1, 0, 0, 0, 2'(b), 0, 0);
            check(busy_len == T_W && !o_commit, "R10 sr cycle", {busy_len, o_commit}, T_W << 1);
            check(bp == 2'(b), "R10 bp loaded", bp, b);
            check(o_wel == 0, "R10 wel cleared", o_wel, 0);
            for (int p = 0; p < 128; p++) begin
                int off, len, a;
                logic [31:0] ring;
                logic [3:0] ebe;
                logic [31:0] edat;
                off = (p + b) % 4;
                len = ((p * 3 + b) % 7) + 1;
                a = p * 4 + off;
                for (int k = 0; k < 4; k++) ring[8*k +: 8] = 8'((p * 7 + k * 29 + b * 5 + 3));
                ebe = '0; edat = '0;
                for (int s = 0; s < 4; s++) begin
                    int r;
                    r = (s - off + 4) % 4;
                    ebe[s] = (len >= 4) || (r < len);
                    if (ebe[s]) edat[8*s +: 8] = ring[8*r +: 8];
                end
                pulse_wren();
                run_req(0, a, len, ring, 0, 0, 0);
                if (exp_locked(b, a)) begin
                    check(busy_len == 0 && !o_commit, "R9 locked dropped", busy_len, 0);
                    check(o_wel == 1, "R9 wel kept", o_wel, 1);
                    pulse_wrdi();
                end else begin
                    check(busy_len == T_W && o_commit, "R9 open writes", busy_len, T_W);
                    check(o_addr == ADDR_W'(p * 4), "R7 addr", o_addr, p * 4);
                    check(o_be == ebe, "R8 lanes", o_be, ebe);
                    check((o_data & {{8{ebe[3]}}, {8{ebe[2]}}, {8{ebe[1]}}, {8{ebe[0]}}}) == edat,
                          "R8 data", o_data, edat);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule